// File: doc/BRIEF.md
# Indexed Remap Configuration Decoder

This block performs the state update of an indexed-remap setup operation. One strobe carries a 5-bit operand mask, a mask-mode bit, a 5-bit index-register field, a 5-bit dimension field, and flags for 2D order (yx), dimension skip and element width. The current maximum vector length also arrives with the strobe. In response, the block rewrites up to four shape descriptors and the remap part of a status word. That part holds one 2-bit shape selector for each of five operands (inputs 0 to 2, outputs 0 and 1), a 5-bit enable mask and a persistence bit.

There are two modes. In mode 0, all state is cleared first. Shapes are then handed out in order to the operands whose mask bits are set, and the shape number wraps after four. In mode 1, the mask is decoded into a single operand index and a single target shape, and only that pair is touched. A strobe is consumed in one cycle, and its results appear on the registered outputs after the next rising clock edge.

Top module: `remap_index_cfg`

## Requirements
- R1: While reset is held, and after it is released, every shape descriptor, selector, enable bit, the persistence bit and the error flag read zero.
- R2: A mode-0 strobe sets the enable mask equal to the operand mask and clears the persistence bit. The enable mask uses bit 0 for input 0, bit 1 for input 1, bit 2 for input 2, bit 3 for output 0 and bit 4 for output 1.
- R3: In mode 0, the set mask bits are visited from bit 0 to bit 4. Each one takes the next shape number, counting 0,1,2,3 and then wrapping to 0, and that number goes into the operand's selector. The selector of an operand whose mask bit is clear becomes 0.
- R4: In mode 0, every shape that receives an operand is loaded with the new descriptor, and every other shape is cleared to zero.
- R5: In mode 0 with all five mask bits set, input 0 and output 1 both select shape 0.
- R6: In mode 1, mask bits 2:0 give the operand index (0 to 4) and mask bits 4:3 give the target shape. Only that shape's descriptor, that operand's selector (set to the target) and that operand's enable bit (set to 1) change, and the persistence bit is set.
- R7: In mode 1 with an operand index of 5, 6 or 7, no shape, selector, enable bit or persistence bit changes, and the error flag is raised.
- R8: Every accepted strobe that is not a bad mode-1 index clears the error flag.
- R9: Descriptor bits 6:0 hold the index register number, which is the 5-bit field shifted left by two, so the two low bits are zero.
- R10: Descriptor bits 11:7 hold the raw dimension field, which is the first dimension minus one. Bits 18:12 hold the second dimension minus one. When yx=1 and skip=0, the second dimension is ceil(maxvl/(field+1)), and a result of zero is stored as 0. Otherwise the second dimension is 1, stored as 0. Bit 19 holds yx, bit 20 holds skip and bits 22:21 hold the element width.
- R11: When the strobe is low, no output changes, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| valid_i | input | 1 | Update strobe |
| mask_mode_i | input | 1 | 0: allocate in order, 1: single operand/shape |
| rmask_i | input | 5 | Operand mask, or packed index and target in mode 1 |
| ixreg_i | input | 5 | Index register field (upper bits of the register number) |
| dim_i | input | 5 | First dimension minus one |
| yx_i | input | 1 | Request 2D order with a computed second dimension |
| skip_i | input | 1 | Dimension skip flag |
| ew_i | input | 2 | Element width code |
| maxvl_i | input | MVW | Current maximum vector length |
| shape_o | output | 4 x SHW | Shape descriptors, shape 0 in the low word |
| sel_o | output | 5 x 2 | Shape selector for each operand |
| en_o | output | 5 | Remap enable for each operand |
| pst_o | output | 1 | Persistence bit |
| err_o | output | 1 | Bad operand index seen on the last strobe |

## Verification
The case that is hardest to reach is a mode-1 update landing on top of state that is already full. Only a partial change is visible there, so the state must first be populated and the untouched parts must be seen to survive. The stimulus fills every shape with a mode-0 strobe whose mask is all ones. It then sweeps all 32 mode-1 mask values in a single chained sequence, including the bad indices 5 to 7, while a running model follows each change. Separately, the ceiling-divide path is driven through every dimension value against several vector lengths, including 0 and the maximum.

// File: rtl/remap_index_cfg.sv
module remap_index_cfg #(
  parameter int MVW = 7
) (
  input  logic                                    clk,
  input  logic                                    rst_n,
  input  logic                                    valid_i,
  input  logic                                    mask_mode_i,
  input  logic [4:0]                              rmask_i,
  input  logic [4:0]                              ixreg_i,
  input  logic [4:0]                              dim_i,
  input  logic                                    yx_i,
  input  logic                                    skip_i,
  input  logic [1:0]                              ew_i,
  input  logic [MVW-1:0]                          maxvl_i,
  output logic [3:0][7+5+MVW+1+1+2-1:0]           shape_o,
  output logic [4:0][1:0]                         sel_o,
  output logic [4:0]                              en_o,
  output logic                                    pst_o,
  output logic                                    err_o
);
  localparam int NSH = 4;
  localparam int NOP = 5;
  localparam int SHW = 7 + 5 + MVW + 1 + 1 + 2;
  localparam int QW  = MVW + 1;

  logic [QW-1:0]    xdim, vsum, quo;
  logic [MVW-1:0]   ydm1;
  logic [SHW-1:0]   desc;
  logic [2:0]       op;
  logic [1:0]       tgt, alloc;
  logic             bad_op;

  logic [NSH-1:0][SHW-1:0] shape_n;
  logic [NOP-1:0][1:0]     sel_n;
  logic [NOP-1:0]          en_n;
  logic                    pst_n, err_n;

  assign xdim = QW'(dim_i) + QW'(1);
  assign vsum = QW'(maxvl_i) + QW'(dim_i);
  assign quo  = vsum / xdim;
  assign ydm1 = (yx_i && !skip_i && quo != '0) ? MVW'(quo - QW'(1)) : '0;
  assign desc = {ew_i, skip_i, yx_i, ydm1, dim_i, ixreg_i, 2'b00};

  assign op     = rmask_i[2:0];
  assign tgt    = rmask_i[4:3];
  assign bad_op = mask_mode_i && (op > 3'd4);

  always_comb begin
    shape_n = shape_o;
    sel_n   = sel_o;
    en_n    = en_o;
    pst_n   = pst_o;
    err_n   = err_o;
    alloc   = 2'd0;
    if (valid_i) begin
      err_n = bad_op;
      if (!mask_mode_i) begin
        shape_n = '0;
        sel_n   = '0;
        en_n    = rmask_i;
        pst_n   = 1'b0;
        for (int b = 0; b < NOP; b++) begin
          if (rmask_i[b]) begin
            sel_n[b]       = alloc;
            shape_n[alloc] = desc;
            alloc          = alloc + 2'd1;
          end
        end
      end else if (!bad_op) begin
        shape_n[tgt] = desc;
        sel_n[op]    = tgt;
        en_n[op]     = 1'b1;
        pst_n        = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shape_o <= '0;
      sel_o   <= '0;
      en_o    <= '0;
      pst_o   <= 1'b0;
      err_o   <= 1'b0;
    end else begin
      shape_o <= shape_n;
      sel_o   <= sel_n;
      en_o    <= en_n;
      pst_o   <= pst_n;
      err_o   <= err_n;
    end
  end

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> $stable(shape_o) && $stable(sel_o) && $stable(en_o) && $stable(pst_o) && $stable(err_o));

  p_mode0_en_r2: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i && !mask_mode_i |=> en_o == $past(rmask_i) && !pst_o);

  p_all_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i && !mask_mode_i && rmask_i == 5'h1f |=> sel_o[0] == 2'd0 && sel_o[4] == 2'd0);

  p_mode1_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i && mask_mode_i && rmask_i[2:0] <= 3'd4 |=> pst_o && !err_o);

  p_bad_op_r7: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i && mask_mode_i && rmask_i[2:0] > 3'd4 |=> err_o && $stable(shape_o) && $stable(sel_o) && $stable(en_o) && $stable(pst_o));

  p_idx_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    shape_o[0][1:0] == 2'b00 && shape_o[1][1:0] == 2'b00 && shape_o[2][1:0] == 2'b00 && shape_o[3][1:0] == 2'b00);
endmodule

// File: tb/remap_index_cfg_bench.sv
`timescale 1ns/1ps
module remap_index_cfg_bench;
  localparam int MVW = 7;
  localparam int SHW = 23;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic valid_i = 1'b0, mask_mode_i = 1'b0, yx_i = 1'b0, skip_i = 1'b0;
  logic [4:0] rmask_i = '0, ixreg_i = '0, dim_i = '0;
  logic [1:0] ew_i = '0;
  logic [MVW-1:0] maxvl_i = '0;
  logic [3:0][SHW-1:0] shape_o;
  logic [4:0][1:0] sel_o;
  logic [4:0] en_o;
  logic pst_o, err_o;

  logic [3:0][SHW-1:0] m_shape;
  logic [4:0][1:0] m_sel;
  logic [4:0] m_en;
  logic m_pst, m_err;

  int total = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  remap_index_cfg #(.MVW(MVW)) u_remap_index_cfg (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .mask_mode_i(mask_mode_i),
    .rmask_i(rmask_i), .ixreg_i(ixreg_i), .dim_i(dim_i), .yx_i(yx_i),
    .skip_i(skip_i), .ew_i(ew_i), .maxvl_i(maxvl_i), .shape_o(shape_o),
    .sel_o(sel_o), .en_o(en_o), .pst_o(pst_o), .err_o(err_o));

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [SHW-1:0] mk_desc(logic [4:0] g, logic [4:0] d, logic y, logic s,
                                             logic [1:0] e, logic [MVW-1:0] mv);
    int x, c, yd;
    x = int'(d) + 1;
    c = (int'(mv) + x - 1) / x;
    yd = (y && !s && c > 0) ? c - 1 : 0;
    return {e, s, y, 7'(yd), d, g, 2'b00};
  endfunction

  task automatic check_all(input string rs, input string rsel, input string ren);
    chk(rs, 128'(shape_o), 128'(m_shape));
    chk(rsel, 128'(sel_o), 128'(m_sel));
    chk(ren, 128'({en_o, pst_o, err_o}), 128'({m_en, m_pst, m_err}));
  endtask

  task automatic op_run(input logic mm, input logic [4:0] rm, input logic [4:0] g, input logic [4:0] d,
                        input logic y, input logic s, input logic [1:0] e, input logic [MVW-1:0] mv,
                        input bit strobe);
    logic [SHW-1:0] ds;
    int nx;
    ds = mk_desc(g, d, y, s, e, mv);
    if (strobe) begin
      if (!mm) begin
        m_shape = '0; m_sel = '0; m_en = rm; m_pst = 1'b0; m_err = 1'b0; nx = 0;
        for (int b = 0; b < 5; b++)
          if (rm[b]) begin m_sel[b] = 2'(nx); m_shape[nx] = ds; nx = (nx + 1) % 4; end
      end else if (rm[2:0] > 3'd4) begin
        m_err = 1'b1;
      end else begin
        m_shape[rm[4:3]] = ds; m_sel[rm[2:0]] = rm[4:3]; m_en[rm[2:0]] = 1'b1;
        m_pst = 1'b1; m_err = 1'b0;
      end
    end
    @(negedge clk);
    valid_i = strobe; mask_mode_i = mm; rmask_i = rm; ixreg_i = g; dim_i = d;
    yx_i = y; skip_i = s; ew_i = e; maxvl_i = mv;
    @(negedge clk);
    valid_i = 1'b0;
  endtask

  initial begin
    repeat (1000000) @(posedge clk);
    if (!done) begin
      fails++; total++;
      $display("FAIL watchdog act=running exp=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    m_shape = '0; m_sel = '0; m_en = '0; m_pst = 1'b0; m_err = 1'b0;
    repeat (3) @(negedge clk);
    check_all("R1 shapes under reset", "R1 sel under reset", "R1 en/pst/err under reset");
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1 shapes", "R1 sel", "R1 en/pst/err");

    for (int r = 0; r < 32; r++) begin
      op_run(1'b0, 5'(r), 5'(r * 7), 5'(r % 9), r[0], r[1], 2'(r), 7'(r * 5), 1'b1);
      check_all("R4/R9/R10 mode0 shapes", "R3/R5 mode0 selectors", "R2/R8 mode0 enable");
      if (r == 31) chk("R5 in0 and out1 share shape0", 128'({sel_o[0], sel_o[4]}), 128'(0));
    end

    op_run(1'b0, 5'h1f, 5'd3, 5'd2, 1'b1, 1'b0, 2'd1, 7'd20, 1'b1);
    check_all("R4 fill", "R3 fill", "R2 fill");
    for (int r = 0; r < 32; r++) begin
      op_run(1'b1, 5'(r), 5'(31 - r), 5'(r), r[1], r[2], 2'(r >> 1), 7'(127 - r), 1'b1);
      if (r[2:0] > 4) begin
        check_all("R7 bad index shapes", "R7 bad index selectors", "R7 bad index flags");
        chk("R7 err raised", 128'(err_o), 128'(1));
      end else begin
        check_all("R6 mode1 shapes", "R6 mode1 selectors", "R6/R8 mode1 flags");
      end
    end

    op_run(1'b1, 5'd7, 5'd0, 5'd0, 1'b0, 1'b0, 2'd0, 7'd0, 1'b1);
    op_run(1'b0, 5'b01010, 5'd9, 5'd4, 1'b1, 1'b1, 2'd3, 7'd50, 1'b0);
    check_all("R11 hold shapes", "R11 hold selectors", "R11 hold flags");
    op_run(1'b1, 5'b11001, 5'd9, 5'd4, 1'b1, 1'b1, 2'd3, 7'd50, 1'b1);
    chk("R8 err cleared", 128'(err_o), 128'(0));

    for (int d = 0; d < 32; d++) begin
      for (int v = 0; v < 6; v++) begin
        logic [6:0] mv;
        mv = (v == 0) ? 7'd0 : (v == 1) ? 7'd1 : (v == 2) ? 7'd5 : (v == 3) ? 7'd64 :
             (v == 4) ? 7'd127 : 7'(d + 1);
        op_run(1'b1, 5'b10011, 5'(d), 5'(d), 1'b1, 1'b0, 2'd2, mv, 1'b1);
        chk("R10 ceil ydim", 128'(shape_o[2]), 128'(mk_desc(5'(d), 5'(d), 1'b1, 1'b0, 2'd2, mv)));
        op_run(1'b1, 5'b10011, 5'(d), 5'(d), 1'b1, 1'b1, 2'd1, mv, 1'b1);
        chk("R10 skip ydim", 128'(shape_o[2][18:12]), 128'(0));
      end
    end
    chk("R9 index reg", 128'(shape_o[2][6:0]), 128'({5'd31, 2'b00}));

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule